// File: doc/BRIEF.md
# Stochastic Dicode Triangle Node

This block is one triangle node of a bit-serial message-passing detector for the dicode partial-response channel, whose output is the current input bit minus the previous one. It receives three fixed-point channel likelihoods, one for each channel output value -1, 0 and +1. It also receives the stochastic message bit `q_in` from the bit node of the previous channel input. From these it produces the stochastic message bit `r_out` that goes toward the bit node of the current channel input.

Each decoding cycle the node turns the three likelihoods into stochastic bits. It does this by comparing each likelihood with one shared pseudo-random word, supplied from outside, that changes from cycle to cycle. Plain gates then form two streams from the trellis of the dicode channel:
- the numerator stream, where the current bit is 1,
- the denominator stream, where the current bit is 0.

A JK flip-flop turns the two streams into their ratio. The dicode graph has no cycles, so the output is the flip-flop state itself, with no re-randomizing memory. A decoding cycle is one clock with `cyc_en` high. In each such cycle the node exchanges one bit.

Top module: `stoch_dicode_tri`

## Requirements
- R1: For each symbol s in {-1, 0, +1}, the symbol bit is 1 exactly when the unsigned likelihood of s is strictly greater than `rnd`. When the likelihood equals `rnd` the bit is 0, and when `rnd` is all ones every bit is 0.
- R2: The numerator bit P1 equals (bit(+1) AND NOT `q_in`) OR (bit(0) AND `q_in`).
- R3: The denominator bit P0 equals (bit(0) AND NOT `q_in`) OR (bit(-1) AND `q_in`).
- R4: In a decoding cycle with P1=1 and P0=0, `r_out` is 1 after that clock edge.
- R5: In a decoding cycle with P1=0 and P0=1, `r_out` is 0 after that clock edge.
- R6: In a decoding cycle with P1=0 and P0=0, `r_out` keeps its value.
- R7: In a decoding cycle with P1=1 and P0=1, `r_out` inverts.
- R8: On a clock with `cyc_en` low, `r_out` does not change, whatever the other inputs are.
- R9: While `rst_n` is low at a clock edge, `r_out` becomes 0, and reset takes priority over `cyc_en`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cyc_en | input | 1 | High for a decoding cycle |
| lik_neg | input | LW | Likelihood of channel output -1 (unsigned, full scale 2^LW) |
| lik_zero | input | LW | Likelihood of channel output 0 |
| lik_pos | input | LW | Likelihood of channel output +1 |
| q_in | input | 1 | Incoming stochastic bit from the previous-input bit node |
| rnd | input | LW | Pseudo-random word for this cycle |
| r_out | output | 1 | Outgoing stochastic bit toward the current-input bit node |

## Verification
The comparators and the trellis gates are combinational, and the JK state is the only register on the way to `r_out`. So every result of a decoding cycle shows at `r_out` one clock edge after the inputs are applied, and a reset shows after one edge too. The bench applies inputs two nanoseconds after a rising edge and samples `r_out` two nanoseconds after the next rising edge. Each check therefore sees the effect of exactly one edge. A reference model in the bench follows the same one-edge timing while it is fed pseudo-random words, Q bits and enables.

// File: rtl/stoch_dicode_pkg.sv
package stoch_dicode_pkg;

  localparam int NSYM     = 3;
  localparam int SYM_NEG  = 0;
  localparam int SYM_ZERO = 1;
  localparam int SYM_POS  = 2;

  typedef enum logic [1:0] {
    JK_HOLD = 2'b00,
    JK_CLR  = 2'b01,
    JK_SET  = 2'b10,
    JK_TGL  = 2'b11
  } jk_act_e;

  // likelihood above the random word gives a one
  function automatic logic f_to_bit(input logic [31:0] lik, input logic [31:0] rnd);
    return lik > rnd;
  endfunction

  // stream for current bit 1: previous bit 0 gives y=+1, previous 1 gives y=0
  function automatic logic f_num(input logic b_pos, input logic b_zero, input logic q);
    return (b_pos & ~q) | (b_zero & q);
  endfunction

  // stream for current bit 0: previous bit 0 gives y=0, previous 1 gives y=-1
  function automatic logic f_den(input logic b_zero, input logic b_neg, input logic q);
    return (b_zero & ~q) | (b_neg & q);
  endfunction

  function automatic jk_act_e f_jk_act(input logic j, input logic k);
    return jk_act_e'({j, k});
  endfunction

  function automatic logic f_jk_next(input logic cur, input logic j, input logic k);
    logic nxt;
    case (f_jk_act(j, k))
      JK_SET:  nxt = 1'b1;
      JK_CLR:  nxt = 1'b0;
      JK_TGL:  nxt = ~cur;
      default: nxt = cur;
    endcase
    return nxt;
  endfunction

endpackage

// File: rtl/sdt_lik_cmp.sv
module sdt_lik_cmp
  import stoch_dicode_pkg::*;
#(
  parameter int LW = 8
) (
  input  logic [NSYM-1:0][LW-1:0] lik,
  input  logic [LW-1:0]           rnd,
  output logic [NSYM-1:0]         sym_bits
);

  localparam int PADW = 32 - LW;

  for (genvar s = 0; s < NSYM; s++) begin : g_sym
    always_comb begin
      sym_bits[s] = f_to_bit({{PADW{1'b0}}, lik[s]}, {{PADW{1'b0}}, rnd});
    end
  end

endmodule

// File: rtl/sdt_trellis_terms.sv
module sdt_trellis_terms
  import stoch_dicode_pkg::*;
(
  input  logic [NSYM-1:0] sym_bits,
  input  logic            q_in,
  output logic            p1_bit,
  output logic            p0_bit
);

  logic q_n;
  logic t_pos_q0;
  logic t_zero_q1;
  logic t_zero_q0;
  logic t_neg_q1;

  assign q_n       = ~q_in;
  assign t_pos_q0  = sym_bits[SYM_POS]  & q_n;
  assign t_zero_q1 = sym_bits[SYM_ZERO] & q_in;
  assign t_zero_q0 = sym_bits[SYM_ZERO] & q_n;
  assign t_neg_q1  = sym_bits[SYM_NEG]  & q_in;

  assign p1_bit = t_pos_q0  | t_zero_q1;
  assign p0_bit = t_zero_q0 | t_neg_q1;

endmodule

// File: rtl/sdt_jk_div.sv
module sdt_jk_div
  import stoch_dicode_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic j,
  input  logic k,
  output logic q
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      q <= 1'b0;
    end else if (en) begin
      q <= f_jk_next(q, j, k);
    end
  end

endmodule

// File: rtl/stoch_dicode_tri.sv
module stoch_dicode_tri
  import stoch_dicode_pkg::*;
#(
  parameter int LW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cyc_en,
  input  logic [LW-1:0] lik_neg,
  input  logic [LW-1:0] lik_zero,
  input  logic [LW-1:0] lik_pos,
  input  logic          q_in,
  input  logic [LW-1:0] rnd,
  output logic          r_out
);

  logic [NSYM-1:0][LW-1:0] lik_vec;
  logic [NSYM-1:0]         sym_bits;
  logic                    p1_bit;
  logic                    p0_bit;

  always_comb begin
    lik_vec[SYM_NEG]  = lik_neg;
    lik_vec[SYM_ZERO] = lik_zero;
    lik_vec[SYM_POS]  = lik_pos;
  end

  sdt_lik_cmp #(.LW(LW)) u_cmp (
    .lik      (lik_vec),
    .rnd      (rnd),
    .sym_bits (sym_bits)
  );

  sdt_trellis_terms u_terms (
    .sym_bits (sym_bits),
    .q_in     (q_in),
    .p1_bit   (p1_bit),
    .p0_bit   (p0_bit)
  );

  sdt_jk_div u_div (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (cyc_en),
    .j     (p1_bit),
    .k     (p0_bit),
    .q     (r_out)
  );

endmodule

// File: rtl/stoch_dicode_tri_chk.sv
module stoch_dicode_tri_chk
  import stoch_dicode_pkg::*;
#(
  parameter int LW = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic            cyc_en,
  input logic [LW-1:0]   lik_neg,
  input logic [LW-1:0]   lik_zero,
  input logic [LW-1:0]   lik_pos,
  input logic            q_in,
  input logic [LW-1:0]   rnd,
  input logic [NSYM-1:0] sym_bits,
  input logic            p1_bit,
  input logic            p0_bit,
  input logic            r_out
);

  p_rnd_max_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (rnd == {LW{1'b1}}) |-> (sym_bits == '0));

  p_zero_lik_r1: assert property (@(posedge clk) disable iff (!rst_n)
    ((lik_neg == '0) |-> !sym_bits[SYM_NEG]) and
    ((lik_zero == '0) |-> !sym_bits[SYM_ZERO]) and
    ((lik_pos == '0) |-> !sym_bits[SYM_POS]));

  p_num_sel_r2: assert property (@(posedge clk) disable iff (!rst_n)
    q_in ? (p1_bit == sym_bits[SYM_ZERO]) : (p1_bit == sym_bits[SYM_POS]));

  p_den_sel_r3: assert property (@(posedge clk) disable iff (!rst_n)
    q_in ? (p0_bit == sym_bits[SYM_NEG]) : (p0_bit == sym_bits[SYM_ZERO]));

  p_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_en && p1_bit && !p0_bit) |=> r_out);

  p_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_en && !p1_bit && p0_bit) |=> !r_out);

  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_en && !p1_bit && !p0_bit) |=> $stable(r_out));

  p_toggle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_en && p1_bit && p0_bit) |=> (r_out != $past(r_out)));

  p_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !cyc_en |=> $stable(r_out));

endmodule

bind stoch_dicode_tri stoch_dicode_tri_chk #(.LW(LW)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .cyc_en   (cyc_en),
  .lik_neg  (lik_neg),
  .lik_zero (lik_zero),
  .lik_pos  (lik_pos),
  .q_in     (q_in),
  .rnd      (rnd),
  .sym_bits (sym_bits),
  .p1_bit   (p1_bit),
  .p0_bit   (p0_bit),
  .r_out    (r_out)
);

// File: tb/stoch_dicode_tri_bench.sv
`timescale 1ns/1ps
module stoch_dicode_tri_bench;

  localparam int LW = 8;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          cyc_en;
  logic [LW-1:0] lik_neg, lik_zero, lik_pos, rnd;
  logic          q_in;
  logic          r_out;

  int n_checks = 0;
  int n_fail   = 0;
  logic model;
  logic [15:0] lf;

  always #10 clk = ~clk;

  stoch_dicode_tri #(.LW(LW)) u_stoch_dicode_tri (
    .clk(clk), .rst_n(rst_n), .cyc_en(cyc_en),
    .lik_neg(lik_neg), .lik_zero(lik_zero), .lik_pos(lik_pos),
    .q_in(q_in), .rnd(rnd), .r_out(r_out)
  );

  task automatic chk(input logic act, input logic exp, input string tag);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: r_out=%b expected %b", tag, act, exp);
    end
  endtask

  // apply inputs, let one edge pass, sample 2 ns after it
  task automatic step(input logic en, input logic [LW-1:0] n, input logic [LW-1:0] z,
                      input logic [LW-1:0] p, input logic q, input logic [LW-1:0] r);
    cyc_en = en; lik_neg = n; lik_zero = z; lik_pos = p; q_in = q; rnd = r;
    @(posedge clk);
    #2;
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    step(1'b0, 8'd0, 8'd0, 8'd0, 1'b0, 8'd0);
    step(1'b0, 8'd0, 8'd0, 8'd0, 1'b0, 8'd0);
    chk(r_out, 1'b0, "R9 reset state");
    rst_n = 1'b1;
  endtask

  task automatic t_set_clear_q0();
    step(1'b1, 8'd0, 8'd0, 8'd50, 1'b0, 8'd0);
    chk(r_out, 1'b1, "R2 R4 set via +1 with q=0");
    step(1'b1, 8'd0, 8'd50, 8'd0, 1'b0, 8'd0);
    chk(r_out, 1'b0, "R3 R5 clear via 0 with q=0");
    step(1'b1, 8'd200, 8'd0, 8'd0, 1'b0, 8'd0);
    chk(r_out, 1'b0, "R3 -1 ignored with q=0 (hold at 0)");
  endtask

  task automatic t_set_clear_q1();
    step(1'b1, 8'd0, 8'd30, 8'd0, 1'b1, 8'd0);
    chk(r_out, 1'b1, "R2 R4 set via 0 with q=1");
    step(1'b1, 8'd0, 8'd0, 8'd200, 1'b1, 8'd0);
    chk(r_out, 1'b1, "R2 +1 ignored with q=1 (hold at 1)");
    step(1'b1, 8'd30, 8'd0, 8'd0, 1'b1, 8'd0);
    chk(r_out, 1'b0, "R3 R5 clear via -1 with q=1");
  endtask

  task automatic t_hold_toggle();
    step(1'b1, 8'd0, 8'd0, 8'd0, 1'b0, 8'd0);
    chk(r_out, 1'b0, "R6 hold at 0");
    step(1'b1, 8'd0, 8'd9, 8'd9, 1'b0, 8'd0);
    chk(r_out, 1'b1, "R7 toggle 0->1");
    step(1'b1, 8'd0, 8'd0, 8'd0, 1'b1, 8'd0);
    chk(r_out, 1'b1, "R6 hold at 1");
    step(1'b1, 8'd9, 8'd9, 8'd0, 1'b1, 8'd0);
    chk(r_out, 1'b0, "R7 toggle 1->0");
  endtask

  task automatic t_cmp_boundary();
    step(1'b1, 8'd0, 8'd0, 8'd100, 1'b0, 8'd100);
    chk(r_out, 1'b0, "R1 likelihood equal to rnd gives 0");
    step(1'b1, 8'd0, 8'd0, 8'd101, 1'b0, 8'd100);
    chk(r_out, 1'b1, "R1 likelihood one above rnd gives 1");
    step(1'b1, 8'd255, 8'd255, 8'd255, 1'b0, 8'd255);
    chk(r_out, 1'b1, "R1 rnd all ones gives no bits (hold)");
  endtask

  task automatic t_enable_low();
    step(1'b0, 8'd0, 8'd90, 8'd0, 1'b0, 8'd0);
    chk(r_out, 1'b1, "R8 no change with cyc_en low (clear inputs)");
    step(1'b0, 8'd90, 8'd90, 8'd90, 1'b1, 8'd0);
    chk(r_out, 1'b1, "R8 no change with cyc_en low (toggle inputs)");
  endtask

  task automatic t_reset_priority();
    rst_n = 1'b0;
    step(1'b1, 8'd0, 8'd0, 8'd77, 1'b0, 8'd0);
    chk(r_out, 1'b0, "R9 reset beats set");
    rst_n = 1'b1;
    step(1'b1, 8'd0, 8'd0, 8'd77, 1'b0, 8'd0);
    chk(r_out, 1'b1, "R9 R4 set after reset release");
  endtask

  task automatic t_random_model(input logic [LW-1:0] n, input logic [LW-1:0] z,
                                input logic [LW-1:0] p, input int cycles);
    logic bn, bz, bp, j, k, en, q;
    logic [LW-1:0] r;
    for (int i = 0; i < cycles; i++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      r  = lf[7:0];
      q  = lf[8];
      en = lf[9] | lf[11];
      bn = n > r; bz = z > r; bp = p > r;
      j  = q ? bz : bp;
      k  = q ? bn : bz;
      if (en) begin
        if (j && !k)      model = 1'b1;
        else if (!j && k) model = 1'b0;
        else if (j && k)  model = ~model;
      end
      step(en, n, z, p, q, r);
      chk(r_out, model, "R1 R2 R3 R8 random model");
    end
  endtask

  initial begin
    #(20 * 200000);
    n_fail++;
    n_checks++;
    $display("FAIL watchdog: r_out=%b expected finish", r_out);
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0; cyc_en = 1'b0; q_in = 1'b0;
    lik_neg = '0; lik_zero = '0; lik_pos = '0; rnd = '0;
    #3;
    t_reset();
    t_set_clear_q0();
    t_set_clear_q1();
    t_hold_toggle();
    t_cmp_boundary();
    t_enable_low();
    t_reset_priority();
    model = r_out === 1'b1;
    lf = 16'hACE1;
    t_random_model(8'd40, 8'd120, 8'd200, 300);
    t_random_model(8'd220, 8'd10, 8'd60, 300);
    t_random_model(8'd128, 8'd128, 8'd128, 300);
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule